// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus and carries out one of three write-type operations: program a single byte, erase one 64 KB sector, or erase the whole device. A request names the operation, an address and a data byte. The block then issues the fixed series of unlock and command bus writes, with the chip select, write strobe and output enable placed on clock-cycle boundaries that meet the flash's minimum pulse widths. After the last write it repeatedly reads back a status location and watches data bit 7 until the device signals completion or a per-operation time limit runs out.

All strobe widths and time limits are parameters given in nanoseconds or microseconds and turned into cycle counts from the clock period parameter, so the same RTL fits a different clock by changing one number. The controller owns the bus only while it is busy. When idle it leaves every strobe inactive and the data lines undriven.

The control FSM has six states. IDLE accepts a request. CMD starts one bus write. CMD_WAIT waits for that write and either steps to the next CMD or, after the last step, goes to POLL. POLL starts one status read. POLL_WAIT goes to FINISH on a match or on timeout, and otherwise goes back to POLL. FINISH gives the one-cycle completion pulse and returns to IDLE. The write engine moves through W_IDLE, W_SETUP, W_LOW and W_HIGH. The read engine moves through P_IDLE, P_GAP and P_READ.

Top module: `nor_cmd_seq`

## Requirements
- R1: Operation code 01 (program) produces exactly four bus writes, in this order: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R2: Operation codes 10 (sector erase) and 11 (chip erase) produce exactly six bus writes: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, then a last write. For chip erase the last write is 10h to 5555h. For sector erase it is 30h to the request address with its low 16 bits cleared.
- R3: Every bus write holds the write strobe low for at least ceil(45 ns / clock period) cycles. Between two writes of one operation the strobe stays high for at least ceil(20 ns / clock period) cycles. While the strobe is low, chip select is low, the data lines are driven, and address and data do not change.
- R4: Each status read holds the output enable low for at least the configured access count, with the data lines undriven and the write strobe high. The output enable is high for at least one cycle between reads. The read address is the request address for a program, the sector base for a sector erase, and 0 for a chip erase.
- R5: The operation completes without error when a status read returns bit 7 equal to bit 7 of the programmed data (program), or equal to 1 (either erase). Completion is a `done` pulse of exactly one cycle with `err` low.
- R6: `busy` is high from the cycle after a request is accepted until the `done` cycle, and it is low during the `done` cycle.
- R7: A request is ignored when it arrives while the block is busy or finishing, or when it carries operation code 00. An ignored request causes no bus write and does not change the write sequence in progress.
- R8: Once polling starts, a counter limits it to the operation's maximum time: 300 µs for a program, 15 s for a sector erase and 256 s for a chip erase, each converted to cycles. When the counter expires, `done` and `err` pulse together for one cycle and the bus returns to idle.
- R9: After reset `busy`, `done` and `err` are low, chip select, write strobe and output enable are high, and the data lines are not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | 01 program, 10 sector erase, 11 chip erase, 00 none |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_o | output | DATA_W | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable for fl_dq_o on the shared data lines |
| fl_dq_i | input | DATA_W | Data read from the flash |
| fl_cs_n | output | 1 | Chip select, active low |
| fl_we_n | output | 1 | Write strobe, active low |
| fl_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume that `fl_dq_i` is settled before the last cycle of each read window and stays stable across it. They also assume that reset is applied before any request. The bench's flash model changes its returned data only on a rising edge of the output enable, so each read samples a stable value. The model moves to the completed value only after a chosen number of busy reads, or never in the timeout runs. Requests are raised only while `busy` and `done` are both low, except for the deliberate mid-operation and code-00 requests that test R7.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PROG = 2'b01,
        OP_SECT = 2'b10,
        OP_CHIP = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_CMD_WAIT,
        S_POLL,
        S_POLL_WAIT,
        S_FINISH
    } seq_st_e;

    typedef enum logic [1:0] {
        W_IDLE,
        W_SETUP,
        W_LOW,
        W_HIGH
    } wr_st_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_GAP,
        P_READ
    } rd_st_e;

    localparam logic [15:0] UNLK_ADR_A = 16'h5555;
    localparam logic [15:0] UNLK_ADR_B = 16'h2AAA;
    localparam logic [7:0]  UNLK_DAT_A = 8'hAA;
    localparam logic [7:0]  UNLK_DAT_B = 8'h55;
    localparam logic [7:0]  CMD_PROG   = 8'hA0;
    localparam logic [7:0]  CMD_ERASE  = 8'h80;
    localparam logic [7:0]  CMD_CHIP   = 8'h10;
    localparam logic [7:0]  CMD_SECT   = 8'h30;

endpackage

// File: rtl/nor_wr_strobe.sv
module nor_wr_strobe
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int DATA_W   = 8,
    parameter int LOW_CYC  = 6,
    parameter int HIGH_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              act,
    output logic              done_p,
    output logic              cs_n,
    output logic              we_n,
    output logic              dq_oe,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq
);

    localparam int MAX_CYC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    wr_st_e            st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= W_IDLE;
            cnt <= '0;
            a_q <= '0;
            d_q <= '0;
        end else begin
            st <= st_nx;
            if (st_nx != st || st == W_IDLE) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
            if (start && st == W_IDLE) begin
                a_q <= addr_in;
                d_q <= data_in;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            W_IDLE:  if (start) st_nx = W_SETUP;
            W_SETUP: st_nx = W_LOW;
            W_LOW:   if (cnt == CNT_W'(LOW_CYC - 1))  st_nx = W_HIGH;
            W_HIGH:  if (cnt == CNT_W'(HIGH_CYC - 1)) st_nx = W_IDLE;
            default: st_nx = W_IDLE;
        endcase
    end

    always_comb begin
        act    = (st != W_IDLE);
        cs_n   = (st == W_IDLE);
        we_n   = (st != W_LOW);
        dq_oe  = (st != W_IDLE);
        addr   = a_q;
        dq     = d_q;
        done_p = (st == W_HIGH) && (cnt == CNT_W'(HIGH_CYC - 1));
    end

    // independent run-length counter for the strobe-low width check
    logic [CNT_W:0] low_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     low_run <= '0;
        else if (!we_n) low_run <= low_run + 1'b1;
        else            low_run <= '0;
    end

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && $past(!we_n)) |-> ($stable(addr) && $stable(dq))); // R3
    AST_WR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && dq_oe)); // R3
    AST_WR_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (low_run >= (CNT_W+1)'(LOW_CYC))); // R3

endmodule

// File: rtl/nor_poll_rd.sv
module nor_poll_rd
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W  = 21,
    parameter int ACC_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              dq_msb,
    output logic              act,
    output logic              cs_n,
    output logic              oe_n,
    output logic [ADDR_W-1:0] addr,
    output logic              rd_valid,
    output logic              rd_msb
);

    localparam int CNT_W = $clog2(ACC_CYC + 1);

    rd_st_e            st, st_nx;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] a_q;
    logic              last_cyc;

    assign last_cyc = (st == P_READ) && (cnt == CNT_W'(ACC_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= P_IDLE;
            cnt      <= '0;
            a_q      <= '0;
            rd_valid <= 1'b0;
            rd_msb   <= 1'b0;
        end else begin
            st <= st_nx;
            if (st_nx != st || st == P_IDLE) cnt <= '0;
            else                             cnt <= cnt + 1'b1;
            if (start && st == P_IDLE) a_q <= addr_in;
            rd_valid <= last_cyc && !abort;
            if (last_cyc) rd_msb <= dq_msb;
        end
    end

    always_comb begin
        st_nx = st;
        if (abort) begin
            st_nx = P_IDLE;
        end else begin
            unique case (st)
                P_IDLE:  if (start) st_nx = P_GAP;
                P_GAP:   st_nx = P_READ;
                P_READ:  if (last_cyc) st_nx = P_IDLE;
                default: st_nx = P_IDLE;
            endcase
        end
    end

    always_comb begin
        act  = (st != P_IDLE);
        cs_n = (st != P_READ);
        oe_n = (st != P_READ);
        addr = a_q;
    end

    // independent measure of the last output-enable low run
    logic [CNT_W:0] oe_run;
    logic           oe_n_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_run <= '0;
            oe_n_q <= 1'b1;
        end else begin
            oe_n_q <= oe_n;
            if (!oe_n) oe_run <= oe_n_q ? (CNT_W+1)'(1) : oe_run + 1'b1;
        end
    end

    AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (oe_run >= (CNT_W+1)'(ACC_CYC))); // R4
    AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && $past(!oe_n)) |-> $stable(addr)); // R4

endmodule

// File: rtl/nor_tmo.sv
module nor_tmo #(
    parameter int W = 36
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] limit,
    output logic         expired
);

    logic [W-1:0] cnt;

    assign expired = !clear && (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (clear)    cnt <= '0;
        else if (!expired) cnt <= cnt + 1'b1;
    end

    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0)); // R8

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 8,
    parameter int WE_LOW_NS   = 45,
    parameter int WE_HIGH_NS  = 20,
    parameter int RD_ACC_CYC  = 12,
    parameter int SECT_LSB    = 16,
    parameter int PROG_MAX_US = 300,
    parameter int SECT_MAX_US = 15_000_000,
    parameter int CHIP_MAX_US = 256_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dq_o,
    output logic              fl_dq_oe,
    input  logic [DATA_W-1:0] fl_dq_i,
    output logic              fl_cs_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);

    localparam int WE_LOW_CYC  = (WE_LOW_NS + CLK_NS - 1) / CLK_NS;
    localparam int WE_HIGH_CYC = (WE_HIGH_NS + CLK_NS - 1) / CLK_NS;

    localparam longint unsigned PROG_TMO = (longint'(PROG_MAX_US) * 1000 + CLK_NS - 1) / CLK_NS;
    localparam longint unsigned SECT_TMO = (longint'(SECT_MAX_US) * 1000 + CLK_NS - 1) / CLK_NS;
    localparam longint unsigned CHIP_TMO = (longint'(CHIP_MAX_US) * 1000 + CLK_NS - 1) / CLK_NS;
    localparam longint unsigned MAX_PS   = (PROG_TMO > SECT_TMO) ? PROG_TMO : SECT_TMO;
    localparam longint unsigned MAX_TMO  = (MAX_PS > CHIP_TMO) ? MAX_PS : CHIP_TMO;
    localparam int              TMO_W    = $clog2(MAX_TMO + 1);

    localparam logic [TMO_W-1:0] PROG_LIM = PROG_TMO[TMO_W-1:0];
    localparam logic [TMO_W-1:0] SECT_LIM = SECT_TMO[TMO_W-1:0];
    localparam logic [TMO_W-1:0] CHIP_LIM = CHIP_TMO[TMO_W-1:0];

    // ---------------- context and state ----------------
    seq_st_e           st, st_nx;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [2:0]        step;
    logic              err_q;

    logic              accept;
    logic [2:0]        last_step;
    logic [ADDR_W-1:0] sect_base;
    logic [ADDR_W-1:0] step_addr;
    logic [DATA_W-1:0] step_data;
    logic [ADDR_W-1:0] poll_addr;
    logic              exp_msb;
    logic              match;
    logic              finish_err;

    logic              wr_start, wr_act, wr_done, wr_cs_n, wr_we_n, wr_dq_oe;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_dq;
    logic              rd_start, rd_abort, rd_act, rd_cs_n, rd_oe_n, rd_valid, rd_msb;
    logic [ADDR_W-1:0] rd_addr;
    logic              tmo_clear, tmo_exp;
    logic [TMO_W-1:0]  tmo_lim;

    logic unused_dq_bits;
    assign unused_dq_bits = ^fl_dq_i[DATA_W-2:0];

    assign accept    = (st == S_IDLE) && req_valid && (req_op != OP_NONE);
    assign last_step = (op_q == OP_PROG) ? 3'd3 : 3'd5;
    assign sect_base = {addr_q[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
    assign match     = rd_valid && (rd_msb == exp_msb);

    // ---------------- command step table ----------------
    always_comb begin
        step_addr = ADDR_W'(UNLK_ADR_A);
        step_data = DATA_W'(UNLK_DAT_A);
        unique case (step)
            3'd0: begin
                step_addr = ADDR_W'(UNLK_ADR_A);
                step_data = DATA_W'(UNLK_DAT_A);
            end
            3'd1, 3'd4: begin
                step_addr = ADDR_W'(UNLK_ADR_B);
                step_data = DATA_W'(UNLK_DAT_B);
            end
            3'd2: begin
                step_addr = ADDR_W'(UNLK_ADR_A);
                step_data = (op_q == OP_PROG) ? DATA_W'(CMD_PROG) : DATA_W'(CMD_ERASE);
            end
            3'd3: begin
                if (op_q == OP_PROG) begin
                    step_addr = addr_q;
                    step_data = data_q;
                end else begin
                    step_addr = ADDR_W'(UNLK_ADR_A);
                    step_data = DATA_W'(UNLK_DAT_A);
                end
            end
            3'd5: begin
                if (op_q == OP_CHIP) begin
                    step_addr = ADDR_W'(UNLK_ADR_A);
                    step_data = DATA_W'(CMD_CHIP);
                end else begin
                    step_addr = sect_base;
                    step_data = DATA_W'(CMD_SECT);
                end
            end
            default: begin
                step_addr = ADDR_W'(UNLK_ADR_A);
                step_data = DATA_W'(UNLK_DAT_A);
            end
        endcase
    end

    // ---------------- per-operation polling setup ----------------
    always_comb begin
        unique case (op_q)
            OP_PROG: begin
                poll_addr = addr_q;
                exp_msb   = data_q[DATA_W-1];
                tmo_lim   = PROG_LIM;
            end
            OP_SECT: begin
                poll_addr = sect_base;
                exp_msb   = 1'b1;
                tmo_lim   = SECT_LIM;
            end
            default: begin
                poll_addr = '0;
                exp_msb   = 1'b1;
                tmo_lim   = CHIP_LIM;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            op_q   <= OP_NONE;
            addr_q <= '0;
            data_q <= '0;
            step   <= '0;
            err_q  <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                step   <= '0;
                err_q  <= 1'b0;
            end
            if (st == S_CMD_WAIT && wr_done && step != last_step)
                step <= step + 1'b1;
            if (st == S_POLL_WAIT && st_nx == S_FINISH)
                err_q <= finish_err;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        st_nx      = st;
        finish_err = 1'b0;
        unique case (st)
            S_IDLE:      if (accept) st_nx = S_CMD;
            S_CMD:       st_nx = S_CMD_WAIT;
            S_CMD_WAIT:  if (wr_done) st_nx = (step == last_step) ? S_POLL : S_CMD;
            S_POLL:      st_nx = S_POLL_WAIT;
            S_POLL_WAIT: begin
                if (match) begin
                    st_nx = S_FINISH;
                end else if (tmo_exp) begin
                    st_nx      = S_FINISH;
                    finish_err = 1'b1;
                end else if (rd_valid) begin
                    st_nx = S_POLL;
                end
            end
            S_FINISH:    st_nx = S_IDLE;
            default:     st_nx = S_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy      = (st != S_IDLE) && (st != S_FINISH);
        done      = (st == S_FINISH);
        err       = (st == S_FINISH) && err_q;
        wr_start  = (st == S_CMD);
        rd_start  = (st == S_POLL);
        rd_abort  = (st == S_POLL_WAIT) && tmo_exp && !match;
        tmo_clear = (st != S_POLL) && (st != S_POLL_WAIT);
        if (wr_act) begin
            fl_addr  = wr_addr;
            fl_dq_o  = wr_dq;
            fl_dq_oe = wr_dq_oe;
            fl_cs_n  = wr_cs_n;
            fl_we_n  = wr_we_n;
            fl_oe_n  = 1'b1;
        end else if (rd_act) begin
            fl_addr  = rd_addr;
            fl_dq_o  = '0;
            fl_dq_oe = 1'b0;
            fl_cs_n  = rd_cs_n;
            fl_we_n  = 1'b1;
            fl_oe_n  = rd_oe_n;
        end else begin
            fl_addr  = '0;
            fl_dq_o  = '0;
            fl_dq_oe = 1'b0;
            fl_cs_n  = 1'b1;
            fl_we_n  = 1'b1;
            fl_oe_n  = 1'b1;
        end
    end

    // ---------------- engines ----------------
    nor_wr_strobe #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .LOW_CYC  (WE_LOW_CYC),
        .HIGH_CYC (WE_HIGH_CYC)
    ) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_start),
        .addr_in (step_addr),
        .data_in (step_data),
        .act     (wr_act),
        .done_p  (wr_done),
        .cs_n    (wr_cs_n),
        .we_n    (wr_we_n),
        .dq_oe   (wr_dq_oe),
        .addr    (wr_addr),
        .dq      (wr_dq)
    );

    nor_poll_rd #(
        .ADDR_W  (ADDR_W),
        .ACC_CYC (RD_ACC_CYC)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (rd_start),
        .abort    (rd_abort),
        .addr_in  (poll_addr),
        .dq_msb   (fl_dq_i[DATA_W-1]),
        .act      (rd_act),
        .cs_n     (rd_cs_n),
        .oe_n     (rd_oe_n),
        .addr     (rd_addr),
        .rd_valid (rd_valid),
        .rd_msb   (rd_msb)
    );

    nor_tmo #(
        .W (TMO_W)
    ) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmo_clear),
        .limit   (tmo_lim),
        .expired (tmo_exp)
    );

    // ---------------- assertions ----------------
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_oe_n |-> (fl_we_n && !fl_dq_oe)); // R4
    AST_ENGINE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_act && rd_act)); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R5
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && fl_cs_n && fl_oe_n && fl_we_n)); // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R6
    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && req_valid && req_op != 2'b00) |=> busy); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> (fl_we_n && fl_oe_n && !fl_dq_oe)); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done); // R8

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

    localparam int AW = 21;
    localparam int DW = 8;
    localparam int ACC = 4;
    localparam int LOW_MIN = 6;    // ceil(45/8)
    localparam int GAP_MIN = 3;    // ceil(20/8)
    localparam int PROG_LIM = 375; // 3 us at 8 ns
    localparam int SECT_LIM = 500; // 4 us
    localparam int CHIP_LIM = 625; // 5 us

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'b00;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          busy, done, err;
    logic [AW-1:0] fl_addr;
    logic [DW-1:0] fl_dq_o;
    logic          fl_dq_oe;
    logic [DW-1:0] fl_dq_i = '0;
    logic          fl_cs_n, fl_we_n, fl_oe_n;

    always #4 clk = ~clk;

    nor_cmd_seq #(
        .ADDR_W(AW), .DATA_W(DW), .CLK_NS(8), .RD_ACC_CYC(ACC),
        .PROG_MAX_US(3), .SECT_MAX_US(4), .CHIP_MAX_US(5)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .err(err), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe),
        .fl_dq_i(fl_dq_i), .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- monitor and flash model ----------------
    int            cyc = 0;
    logic          we_q = 1'b1, oe_q = 1'b1;
    int            low_run, high_run, oe_run;
    int            wr_n, min_low, min_gap, min_oe, polls, poll_bad, done_cnt;
    int            last_rise, done_cyc;
    logic          err_last;
    logic [AW-1:0] cur_a, wr_a [0:7], exp_poll;
    logic [DW-1:0] cur_d, wr_d [0:7];
    int            model_left;
    logic [DW-1:0] model_val;
    logic          busy_msb;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!fl_we_n) begin
                if (we_q) begin
                    if (wr_n > 0 && high_run < min_gap) min_gap = high_run;
                    low_run = 0;
                end
                low_run++;
                cur_a = fl_addr;
                cur_d = fl_dq_o;
            end else begin
                if (!we_q) begin
                    if (low_run < min_low) min_low = low_run;
                    if (wr_n < 8) begin
                        wr_a[wr_n] = cur_a;
                        wr_d[wr_n] = cur_d;
                    end
                    wr_n++;
                    last_rise = cyc;
                    high_run = 0;
                end
                high_run++;
            end
            if (!fl_oe_n) begin
                if (oe_q) oe_run = 0;
                oe_run++;
                if (fl_addr != exp_poll) poll_bad++;
            end else if (!oe_q) begin
                polls++;
                if (oe_run < min_oe) min_oe = oe_run;
                if (model_left > 0) model_left--;
            end
            if (done) begin
                done_cnt++;
                err_last = err;
                done_cyc = cyc;
            end
            we_q = fl_we_n;
            oe_q = fl_oe_n;
        end
        fl_dq_i <= (model_left > 0) ? {busy_msb, 7'($urandom)} : model_val;
    end

    // ---------------- expected values ----------------
    function automatic int n_steps(input logic [1:0] op);
        return (op == 2'b01) ? 4 : 6;
    endfunction

    function automatic logic [AW+DW-1:0] exp_wr(input logic [1:0] op, input logic [AW-1:0] a,
                                                input logic [DW-1:0] d, input int i);
        case (i)
            0:       return {21'h05555, 8'hAA};
            1, 4:    return {21'h02AAA, 8'h55};
            2:       return (op == 2'b01) ? {21'h05555, 8'hA0} : {21'h05555, 8'h80};
            3:       return (op == 2'b01) ? {a, d} : {21'h05555, 8'hAA};
            default: return (op == 2'b11) ? {21'h05555, 8'h10} : {a & 21'h1F0000, 8'h30};
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_poll_addr(input logic [1:0] op, input logic [AW-1:0] a);
        case (op)
            2'b01:   return a;
            2'b10:   return a & 21'h1F0000;
            default: return '0;
        endcase
    endfunction

    function automatic int lim_of(input logic [1:0] op);
        case (op)
            2'b01:   return PROG_LIM;
            2'b10:   return SECT_LIM;
            default: return CHIP_LIM;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        wr_n = 0; min_low = 1000; min_gap = 1000; min_oe = 1000;
        polls = 0; poll_bad = 0; done_cnt = 0; low_run = 0; high_run = 0; oe_run = 0;
        last_rise = 0; done_cyc = 0; err_last = 1'b0;
    endtask

    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input int nbusy, input logic exp_err, input logic poke);
        logic ok;
        clear_stats();
        exp_poll   = exp_poll_addr(op, a);
        model_left = nbusy;
        model_val  = (op == 2'b01) ? d : 8'hFF;
        busy_msb   = (op == 2'b01) ? ~d[7] : 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy === 1'b1, "R6 busy after accept", busy, 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            req_valid = 1'b1; req_op = 2'b11; req_addr = ~a; req_data = ~d;
            @(negedge clk);
            req_valid = 1'b0;
        end
        for (int k = 0; k < 20000 && done_cnt == 0; k++) @(negedge clk);
        chk(done_cnt == 1, "R5 done pulse seen", done_cnt, 1);
        chk(busy === 1'b0, "R6 busy low at done", busy, 0);
        chk(wr_n == n_steps(op), op == 2'b01 ? "R1 write count" : "R2 write count", wr_n, n_steps(op));
        ok = 1'b1;
        for (int i = 0; i < n_steps(op) && i < 8; i++)
            if ({wr_a[i], wr_d[i]} !== exp_wr(op, a, d, i)) begin
                ok = 1'b0;
                $display("FAIL %s write %0d actual=%0h expected=%0h", op == 2'b01 ? "R1" : "R2",
                         i, {wr_a[i], wr_d[i]}, exp_wr(op, a, d, i));
            end
        chk(ok, op == 2'b01 ? "R1 write sequence" : "R2 write sequence", ok, 1);
        chk(min_low >= LOW_MIN, "R3 strobe low width", min_low, LOW_MIN);
        chk(min_gap >= GAP_MIN, "R3 strobe high gap", min_gap, GAP_MIN);
        chk(err_last == exp_err, "R8 err flag", err_last, exp_err);
        chk(poll_bad == 0, "R4 poll address", poll_bad, 0);
        if (!exp_err) begin
            chk(polls == nbusy + 1, "R5 poll count", polls, nbusy + 1);
            chk(min_oe >= ACC, "R4 read window", min_oe, ACC);
        end else begin
            chk((done_cyc - last_rise) >= lim_of(op) && (done_cyc - last_rise) <= lim_of(op) + 30,
                "R8 timeout latency", done_cyc - last_rise, lim_of(op));
        end
        repeat (3) @(negedge clk);
        chk(fl_cs_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R8 bus idle after done",
            {fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        int seed_init;
        seed_init = $urandom(32'h5EED);
        clear_stats();
        model_left = 0; model_val = '0; busy_msb = 1'b0; exp_poll = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err, "R9 reset flags", {busy, done, err}, 0);
        chk(fl_cs_n && fl_we_n && fl_oe_n && !fl_dq_oe, "R9 reset bus",
            {fl_cs_n, fl_we_n, fl_oe_n, fl_dq_oe}, 4'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // op code 00 ignored
        clear_stats();
        req_valid = 1'b1; req_op = 2'b00; req_addr = 21'h12345; req_data = 8'h5A;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(wr_n == 0 && busy == 1'b0 && done_cnt == 0, "R7 op 00 ignored", wr_n, 0);

        // directed corner cases
        run_op(2'b01, 21'h0ABCDE, 8'h80, 3, 1'b0, 1'b0);   // R1 R5 msb one
        run_op(2'b01, 21'h000000, 8'h00, 0, 1'b0, 1'b1);   // R1 R7 busy poke
        run_op(2'b10, 21'h1FFFFF, 8'h00, 2, 1'b0, 1'b0);   // R2 last sector
        run_op(2'b11, 21'h054321, 8'h00, 1, 1'b0, 1'b1);   // R2 R7 chip erase
        run_op(2'b01, 21'h033333, 8'h7F, 100000, 1'b1, 1'b0); // R8 program timeout
        run_op(2'b10, 21'h020000, 8'h00, 100000, 1'b1, 1'b0); // R8 sector timeout

        // constrained random
        for (int n = 0; n < 12; n++) begin
            logic [1:0] op;
            op = 2'($urandom_range(1, 3));
            run_op(op, 21'($urandom), 8'($urandom), int'($urandom_range(0, 5)), 1'b0,
                   1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule